// File: doc/BRIEF.md
# Peripheral Interrupt Collector with Keyed Soft Reset

This block sits beside a serial peripheral core and reduces its six event sources to a single interrupt request. Every event arrives as a one-cycle pulse and is latched into a status register. Software reads that register and clears bits by writing ones back to them. A per-source enable register chooses which latched events may raise the request. A global enable bit then gates the combined request before it leaves the block through a register.

The same register space holds a reset register. When software writes the exact key value to it, the block drives a reset pulse of fixed length into the core. While that pulse lasts, the block also holds its own status, enable and global-enable registers at zero. Any other value written to the reset register is ignored. Register access uses a plain single-cycle write strobe, and the read data follows the address combinationally. No data stream crosses the block's edge, so the block has no valid/ready handshake.

Top module: `pirq_ctrl`

## Requirements
- R1: After power-on reset, every register reads zero, `irq` is low and `core_rst` is low.
- R2: An event pulse on `evt[i]` sets status bit i at offset 0x20 whether or not source i is enabled. The bit assignment is: bit 0 mode fault, bit 1 slave-mode fault, bit 2 transmit empty, bit 3 transmit underrun, bit 4 receive full, bit 5 receive overrun.
- R3: A write to offset 0x20 clears each status bit whose write-data bit is one and leaves the bits written with zero unchanged.
- R4: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R5: Offset 0x28 holds the per-source enables in bits 5..0 and reads back what was written. A latched status bit whose enable is zero does not raise `irq`.
- R6: Offset 0x1C holds the global enable in bit 31. While that bit is zero, `irq` stays low whatever the status and enable registers hold.
- R7: `irq` is registered. It goes high on the clock edge after the one at which the global enable, a status bit and that bit's enable are all set, and it goes low on the edge after that condition ends.
- R8: Writing 0x0000000A to offset 0x40 drives `core_rst` high for exactly 16 clock cycles, starting the cycle after the write.
- R9: Writing any value other than 0x0000000A to offset 0x40 changes neither `core_rst` nor any register.
- R10: The key write clears the status, enable and global-enable registers at the edge where it is taken, and forces `irq` low at that same edge. For as long as `core_rst` stays high, event pulses and register writes are ignored.
- R11: Reads of offset 0x40 and of any offset with no register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle it is high |
| reg_addr | input | 8 | Byte offset of the register being read or written |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt | input | 6 | Single-cycle event pulses from the core, one per source |
| irq | output | 1 | Registered interrupt request |
| core_rst | output | 1 | Reset pulse to the core |

## Verification
The assertions check five rules on every cycle:
- an unmasked event always leaves its status bit set, even during a clearing write;
- a cleared global enable keeps `irq` low on the following edge;
- the soft-clear leaves all three registers at zero;
- a write of any non-key value leaves `core_rst` low;
- every `core_rst` pulse is exactly 16 cycles wide.

Only the bench's scenarios can show the following:
- the bit-to-source assignment;
- that write-one-to-clear leaves the bits written with zero untouched;
- that enables mask individual sources;
- the one-cycle latency of `irq`;
- that writes and events are ignored while the pulse lasts.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned GIE_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_GIE  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_RST  = 8'h40;

  localparam logic [DATA_W-1:0] RST_KEY = 32'h0000_000A;

  typedef enum logic [2:0] {
    SRC_MODE_FAULT  = 3'd0,
    SRC_SLAVE_FAULT = 3'd1,
    SRC_TX_EMPTY    = 3'd2,
    SRC_TX_UNDER    = 3'd3,
    SRC_RX_FULL     = 3'd4,
    SRC_RX_OVER     = 3'd5
  } src_idx_e;
endpackage

// File: rtl/pirq_src_bank.sv
// Latched status and per-source enable bits, one slice per event source.
module pirq_src_bank #(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N_SRC-1:0] evt,
  input  logic             stat_wr,
  input  logic             ena_wr,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] status_q,
  output logic [N_SRC-1:0] enable_q
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    // Set has priority over write-one-to-clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     status_q[i] <= 1'b0;
      else if (clr)                   status_q[i] <= 1'b0;
      else if (evt[i])                status_q[i] <= 1'b1;
      else if (stat_wr && wdata[i])   status_q[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       enable_q[i] <= 1'b0;
      else if (clr)     enable_q[i] <= 1'b0;
      else if (ena_wr)  enable_q[i] <= wdata[i];
    end
  end
endmodule

// File: rtl/pirq_gate.sv
// Global enable bit and the registered, gated interrupt request.
module pirq_gate #(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             gie_wr,
  input  logic             gie_wbit,
  input  logic [N_SRC-1:0] status,
  input  logic [N_SRC-1:0] enable,
  output logic             gie_q,
  output logic             irq
);
  logic pending;

  always_comb pending = |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie_q <= 1'b0;
    else if (clr)     gie_q <= 1'b0;
    else if (gie_wr)  gie_q <= gie_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= !clr && gie_q && pending;
  end
endmodule

// File: rtl/pirq_swrst.sv
// Keyed soft reset: fixed-length pulse to the core plus a local clear.
module pirq_swrst #(
  parameter int unsigned        DATA_W    = 32,
  parameter int unsigned        PULSE_LEN = 16,
  parameter logic [DATA_W-1:0]  KEY       = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              core_rst,
  output logic              soft_clr
);
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] remain_q;
  logic             key_hit;

  // A key write is taken only when no pulse is already running.
  always_comb key_hit = rst_wr && (wdata == KEY) && (remain_q == '0);
  always_comb core_rst = (remain_q != '0);
  always_comb soft_clr = key_hit || core_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (key_hit)         remain_q <= CNT_LOAD;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int unsigned N_SRC     = 6,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  evt,
  output logic              irq,
  output logic              core_rst
);
  logic             soft_clr;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;
  logic             gie_q;
  logic             wr_stat, wr_ena, wr_gie, wr_rst;
  logic             wr_live;

  always_comb begin
    wr_live = reg_wr && !core_rst;
    wr_stat = wr_live && (reg_addr == OFS_STAT);
    wr_ena  = wr_live && (reg_addr == OFS_ENA);
    wr_gie  = wr_live && (reg_addr == OFS_GIE);
    wr_rst  = wr_live && (reg_addr == OFS_RST);
  end

  pirq_swrst #(
    .DATA_W   (DATA_W),
    .PULSE_LEN(PULSE_LEN),
    .KEY      (RST_KEY)
  ) u_swrst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_wr  (wr_rst),
    .wdata   (reg_wdata),
    .core_rst(core_rst),
    .soft_clr(soft_clr)
  );

  pirq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_clr),
    .evt     (evt),
    .stat_wr (wr_stat),
    .ena_wr  (wr_ena),
    .wdata   (reg_wdata[N_SRC-1:0]),
    .status_q(status_q),
    .enable_q(enable_q)
  );

  pirq_gate #(.N_SRC(N_SRC)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_clr),
    .gie_wr  (wr_gie),
    .gie_wbit(reg_wdata[GIE_BIT]),
    .status  (status_q),
    .enable  (enable_q),
    .gie_q   (gie_q),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_GIE:  reg_rdata[GIE_BIT]   = gie_q;
      OFS_STAT: reg_rdata[N_SRC-1:0] = status_q;
      OFS_ENA:  reg_rdata[N_SRC-1:0] = enable_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk
  import pirq_pkg::*;
#(
  parameter int unsigned N_SRC     = 6,
  parameter int unsigned PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [N_SRC-1:0]  evt,
  input logic              irq,
  input logic              core_rst,
  input logic              soft_clr,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q,
  input logic              gie_q
);
  localparam int unsigned HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (core_rst) hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;
  end

  // R2 R4: an event outside a soft clear always leaves its bit set.
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr |=> ((status_q & $past(evt)) == $past(evt)));

  // R6: a cleared global enable keeps the request low.
  a_r6_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !irq);

  // R10: soft clear empties every register.
  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (status_q == '0 && enable_q == '0 && !gie_q && !irq));

  // R9: a non-key write to the reset offset starts no pulse.
  a_r9_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_RST && reg_wdata != RST_KEY && !core_rst)
      |=> !core_rst);

  // R8: pulse width.
  a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (hi_cnt == HW'(PULSE_LEN)));

  a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (hi_cnt < HW'(PULSE_LEN)));
endmodule

bind pirq_ctrl pirq_ctrl_chk #(.N_SRC(N_SRC), .PULSE_LEN(PULSE_LEN)) u_chk (.*);

// File: tb/tb_pirq_ctrl.sv
module tb_pirq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  evt = '0;
  logic        irq;
  logic        core_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pirq_ctrl dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .evt      (evt),
    .irq      (irq),
    .core_rst (core_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(logic [5:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(8'h1C, d); check("R1 gie", d, 0);
    rd(8'h20, d); check("R1 status", d, 0);
    rd(8'h28, d); check("R1 enable", d, 0);
    check("R1 irq", irq, 0);
    check("R1 core_rst", core_rst, 0);
  endtask

  task automatic t_latch_and_w1c();
    logic [31:0] d;
    pulse(6'h01);
    pulse(6'h20);
    rd(8'h20, d); check("R2 latch unmasked", d, 32'h21);
    check("R5 masked irq", irq, 0);
    wr(8'h20, 32'h01);
    rd(8'h20, d); check("R3 w1c partial", d, 32'h20);
    wr(8'h20, 32'h20);
    rd(8'h20, d); check("R3 w1c all", d, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    evt = 6'h04; reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h04;
    @(negedge clk);
    evt = '0; reg_wr = 1'b0;
    rd(8'h20, d); check("R4 set wins", d, 32'h04);
    wr(8'h20, 32'h3F);
  endtask

  task automatic t_enable_gate();
    logic [31:0] d;
    wr(8'h28, 32'h10);
    rd(8'h28, d); check("R5 enable readback", d, 32'h10);
    wr(8'h1C, 32'h8000_0000);
    rd(8'h1C, d); check("R6 gie readback", d, 32'h8000_0000);
    pulse(6'h08);
    @(negedge clk);
    check("R5 other source masked", irq, 0);
    // Status set at the edge inside pulse(); irq one edge later.
    @(negedge clk);
    evt = 6'h10;
    @(negedge clk);
    evt = '0;
    check("R7 irq not yet", irq, 0);
    @(negedge clk);
    check("R7 irq one cycle later", irq, 1);
    wr(8'h1C, 32'h0);
    @(negedge clk);
    check("R6 gie off", irq, 0);
    wr(8'h1C, 32'h8000_0000);
    @(negedge clk);
    check("R7 irq back", irq, 1);
    wr(8'h20, 32'h10);
    check("R7 irq still high edge of clear", irq, 1);
    @(negedge clk);
    check("R7 irq low after clear", irq, 0);
  endtask

  task automatic t_bad_key();
    logic [31:0] d;
    pulse(6'h02);
    wr(8'h40, 32'h05);
    wr(8'h40, 32'h10A);
    check("R9 no pulse", core_rst, 0);
    rd(8'h20, d); check("R9 status kept", d, 32'h0A);
    rd(8'h28, d); check("R9 enable kept", d, 32'h10);
    rd(8'h40, d); check("R11 rst reads zero", d, 0);
    rd(8'h44, d); check("R11 unmapped zero", d, 0);
  endtask

  task automatic t_key_reset();
    logic [31:0] d;
    int width;
    wr(8'h28, 32'h02);
    @(negedge clk);
    check("R7 irq before key", irq, 1);
    wr(8'h40, 32'h0A);
    check("R10 irq cleared", irq, 0);
    rd(8'h20, d); check("R10 status cleared", d, 0);
    rd(8'h28, d); check("R10 enable cleared", d, 0);
    rd(8'h1C, d); check("R10 gie cleared", d, 0);
    width = 0;
    while (core_rst && width < 40) begin
      width++;
      if (width == 3) begin
        evt = 6'h3F; reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h3F;
      end else begin
        evt = '0; reg_wr = 1'b0;
      end
      @(negedge clk);
    end
    evt = '0; reg_wr = 1'b0;
    check("R8 pulse width", width, 16);
    rd(8'h20, d); check("R10 events ignored", d, 0);
    rd(8'h28, d); check("R10 writes ignored", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_latch_and_w1c();
    t_set_wins();
    t_enable_gate();
    t_bad_key();
    t_key_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule